// File: doc/BRIEF.md
# Dual-Path Bridge Control Register File

This block holds the 64-bit control registers of a host-bridge style peripheral and serves them to two requesters. A configuration path, intended for trusted setup traffic, reaches registers by byte address divided by eight. A memory-mapped path reaches the same storage at an index shifted up by ten, so its first word lands on the window base register. Every access is a full 8-byte word. The low three address bits select nothing.

Several indices are write aliases rather than storage. A fault word can be overwritten, masked with AND, or merged with OR. A control word can be overwritten, bit-set or bit-cleared. The window base register accepts writes from the configuration path only. A status register is read-only. Two base registers and a source-compare register keep only their defined fields. Every other index reads as all ones and discards writes. Both kinds of rejected access are flagged in the response.

The decoded window base, its enable bit and the interrupt-number offset from the source-compare register are driven out continuously for the surrounding logic.

Top module: `bridge_regfile`

## Requirements
- R1: `req_ready_o` is always high. Each accepted request produces `rsp_valid_o` for exactly one cycle on the following clock, read data included. Write responses carry zero data.
- R2: A configuration access (`req_mem_i`=0) targets index `addr>>3`. A memory-mapped access (`req_mem_i`=1) targets index `(addr>>3)+0x0a`. Address bits 2:0 are ignored.
- R3: Index 0x00 is the fault word and reads and writes plainly. A write to 0x01 ANDs the data into it. A write to 0x02 ORs the data into it.
- R4: Index 0x0e is the control word and reads and writes plainly. A write to 0x12 ORs the data into it. A write to 0x13 clears every bit that is set in the data.
- R5: Index 0x0a is the window base. A configuration write stores data AND 0x0003fffffff00001. `base_addr_o` is the stored value without bit 0, and `base_en_o` is bit 0. A memory-mapped write to it changes nothing and sets `rsp_err_o`.
- R6: Index 0x0b stores only the bits under 0x0003ffff00000000.
- R7: Implemented read indices are 0x00, 0x06, 0x07, 0x0a, 0x0b, 0x0e, 0x0f, 0x14, 0x15 and 0x1b. A read of any other index, including the aliases 0x01, 0x02, 0x12 and 0x13, returns all ones with `rsp_unimp_o`=1. A write to an index with no write meaning is dropped with `rsp_unimp_o`=1. `rsp_err_o` and `rsp_unimp_o` are never high together.
- R8: Index 0x15 is the interrupt status word. It reads as zero, and a write to it is ignored and sets `rsp_err_o`.
- R9: A write to index 0x1b keeps bits 63:45 (compare field) and bits 35:32 and clears the rest. `irq_offset_o` is bits 63:45 of the stored value and changes only on a write.
- R10: Indices 0x06, 0x07, 0x0f and 0x14 are independent plain 64-bit storage words.
- R11: After reset every register is zero and the response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_mem_i | input | 1 | 1 = memory-mapped path, 0 = configuration path |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Response present |
| rsp_rdata_o | output | 64 | Read data |
| rsp_err_o | output | 1 | Write rejected (privileged or read-only target) |
| rsp_unimp_o | output | 1 | Access to an unimplemented index |
| base_addr_o | output | 64 | Decoded window base address |
| base_en_o | output | 1 | Window enable |
| irq_offset_o | output | 19 | Interrupt-number offset from the compare field |

## Verification
Some properties are checked on every cycle: the one-cycle response timing, the exclusion between the two flags, and the masking of the exported base. The assertions also check that a memory-mapped base write leaves the window untouched and is flagged, that a status write is flagged, and that the offset output holds between writes. Other behaviour needs a reference model running alongside and is shown only by the bench's scenarios. This covers the AND, OR, set and clear arithmetic, the field masks of each register, the index shift between the two paths, the all-ones read of the alias indices, and the independence of the plain storage words.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int DATA_W = 64;

  localparam logic [7:0] IX_FIR      = 8'h00;
  localparam logic [7:0] IX_FIR_AND  = 8'h01;
  localparam logic [7:0] IX_FIR_OR   = 8'h02;
  localparam logic [7:0] IX_BAR      = 8'h0a;
  localparam logic [7:0] IX_BAR2     = 8'h0b;
  localparam logic [7:0] IX_CTL      = 8'h0e;
  localparam logic [7:0] IX_CTL_SET  = 8'h12;
  localparam logic [7:0] IX_CTL_CLR  = 8'h13;
  localparam logic [7:0] IX_STAT     = 8'h15;
  localparam logic [7:0] IX_CMP      = 8'h1b;
  localparam logic [7:0] MEM_BASE    = 8'h0a;

  localparam int N_PLAIN = 4;
  localparam int SLOT_W  = $clog2(N_PLAIN);
  localparam logic [7:0] PLAIN_IDX [N_PLAIN] = '{8'h06, 8'h07, 8'h0f, 8'h14};

  localparam logic [DATA_W-1:0] BAR_KEEP  = 64'h0003_ffff_fff0_0001;
  localparam logic [DATA_W-1:0] BAR_ADDR  = 64'h0003_ffff_fff0_0000;
  localparam logic [DATA_W-1:0] BAR2_KEEP = 64'h0003_ffff_0000_0000;
  localparam logic [DATA_W-1:0] CMP_KEEP  = 64'hffff_e00f_0000_0000;
  localparam int CMP_LSB = 45;
  localparam int CMP_W   = 19;

  typedef enum logic [3:0] {
    OP_UNIMP,
    OP_FIR_WR,
    OP_FIR_AND,
    OP_FIR_OR,
    OP_PLAIN_WR,
    OP_BAR_WR,
    OP_BAR2_WR,
    OP_CTL_WR,
    OP_CTL_SET,
    OP_CTL_CLR,
    OP_CMP_WR,
    OP_REJECT
  } wr_op_e;
endpackage

// File: rtl/brf_decode.sv
module brf_decode
  import brf_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              mem_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output wr_op_e            op_o,
  output logic              plain_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [N_PLAIN-1:0] plain_hit;

  assign idx_o = IDX_W'(addr_i >> 3) + (mem_i ? IDX_W'(MEM_BASE) : '0);

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain_hit
    assign plain_hit[g] = (idx_o == IDX_W'(PLAIN_IDX[g]));
  end

  assign plain_o = |plain_hit;

  always_comb begin
    slot_o = '0;
    for (int i = 0; i < N_PLAIN; i++) begin
      if (plain_hit[i]) slot_o = SLOT_W'(i);
    end
  end

  always_comb begin
    op_o = OP_UNIMP;
    if (plain_o) begin
      op_o = OP_PLAIN_WR;
    end else begin
      case (idx_o)
        IDX_W'(IX_FIR):     op_o = OP_FIR_WR;
        IDX_W'(IX_FIR_AND): op_o = OP_FIR_AND;
        IDX_W'(IX_FIR_OR):  op_o = OP_FIR_OR;
        IDX_W'(IX_BAR):     op_o = mem_i ? OP_REJECT : OP_BAR_WR;
        IDX_W'(IX_BAR2):    op_o = OP_BAR2_WR;
        IDX_W'(IX_CTL):     op_o = OP_CTL_WR;
        IDX_W'(IX_CTL_SET): op_o = OP_CTL_SET;
        IDX_W'(IX_CTL_CLR): op_o = OP_CTL_CLR;
        IDX_W'(IX_STAT):    op_o = OP_REJECT;
        IDX_W'(IX_CMP):     op_o = OP_CMP_WR;
        default:            op_o = OP_UNIMP;
      endcase
    end
  end
endmodule

// File: rtl/brf_regs.sv
module brf_regs
  import brf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  wr_op_e            op_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] fir_o,
  output logic [DATA_W-1:0] bar_o,
  output logic [DATA_W-1:0] bar2_o,
  output logic [DATA_W-1:0] ctl_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic [DATA_W-1:0] plain_o [N_PLAIN]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fir_o  <= '0;
      bar_o  <= '0;
      bar2_o <= '0;
      ctl_o  <= '0;
      cmp_o  <= '0;
    end else if (wr_i) begin
      case (op_i)
        OP_FIR_WR:  fir_o  <= wdata_i;
        OP_FIR_AND: fir_o  <= fir_o & wdata_i;
        OP_FIR_OR:  fir_o  <= fir_o | wdata_i;
        OP_BAR_WR:  bar_o  <= wdata_i & BAR_KEEP;
        OP_BAR2_WR: bar2_o <= wdata_i & BAR2_KEEP;
        OP_CTL_WR:  ctl_o  <= wdata_i;
        OP_CTL_SET: ctl_o  <= ctl_o | wdata_i;
        OP_CTL_CLR: ctl_o  <= ctl_o & ~wdata_i;
        OP_CMP_WR:  cmp_o  <= wdata_i & CMP_KEEP;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        plain_o[g] <= '0;
      end else if (wr_i && op_i == OP_PLAIN_WR && slot_i == SLOT_W'(g)) begin
        plain_o[g] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/bridge_regfile.sv
module bridge_regfile
  import brf_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_mem_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [63:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [63:0]       rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              rsp_unimp_o,
  output logic [63:0]       base_addr_o,
  output logic              base_en_o,
  output logic [18:0]       irq_offset_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  wr_op_e            op;
  logic              is_plain;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] fir_q, bar_q, bar2_q, ctl_q, cmp_q;
  logic [DATA_W-1:0] plain_q [N_PLAIN];
  logic [DATA_W-1:0] rd_val;
  logic              rd_hit;

  brf_decode #(.ADDR_W(ADDR_W)) i_decode (
    .mem_i   (req_mem_i),
    .addr_i  (req_addr_i),
    .idx_o   (idx),
    .op_o    (op),
    .plain_o (is_plain),
    .slot_o  (slot)
  );

  brf_regs i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (req_valid_i && req_we_i),
    .op_i    (op),
    .slot_i  (slot),
    .wdata_i (req_wdata_i),
    .fir_o   (fir_q),
    .bar_o   (bar_q),
    .bar2_o  (bar2_q),
    .ctl_o   (ctl_q),
    .cmp_o   (cmp_q),
    .plain_o (plain_q)
  );

  always_comb begin
    rd_val = '1;
    rd_hit = 1'b1;
    if (is_plain) begin
      rd_val = plain_q[slot];
    end else begin
      case (idx)
        IDX_W'(IX_FIR):  rd_val = fir_q;
        IDX_W'(IX_BAR):  rd_val = bar_q;
        IDX_W'(IX_BAR2): rd_val = bar2_q;
        IDX_W'(IX_CTL):  rd_val = ctl_q;
        IDX_W'(IX_STAT): rd_val = '0;
        IDX_W'(IX_CMP):  rd_val = cmp_q;
        default:         rd_hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
      rsp_unimp_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_rdata_o <= req_we_i ? '0 : rd_val;
        rsp_err_o   <= req_we_i && (op == OP_REJECT);
        rsp_unimp_o <= req_we_i ? (op == OP_UNIMP) : !rd_hit;
      end else begin
        rsp_err_o   <= 1'b0;
        rsp_unimp_o <= 1'b0;
      end
    end
  end

  assign req_ready_o  = 1'b1;
  assign base_addr_o  = bar_q & BAR_ADDR;
  assign base_en_o    = bar_q[0];
  assign irq_offset_o = cmp_q[CMP_LSB +: CMP_W];
endmodule

// File: rtl/brf_checker.sv
module brf_checker
  import brf_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_mem_i,
  input logic              req_we_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic [63:0]       rsp_rdata_o,
  input logic              rsp_err_o,
  input logic              rsp_unimp_o,
  input logic [63:0]       base_addr_o,
  input logic              base_en_o,
  input logic [18:0]       irq_offset_o
);
  logic wr_req, word_zero, word_stat;
  assign wr_req    = req_valid_i && req_we_i;
  assign word_zero = (req_addr_i[ADDR_W-1:3] == '0);
  assign word_stat = (req_addr_i[ADDR_W-1:3] == (ADDR_W-3)'(IX_STAT));

  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o) else $error("rsp missing"); // R1
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o) else $error("spurious rsp"); // R1
  AST_BAR_CFG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && req_mem_i && word_zero) |=>
      (rsp_err_o && $stable(base_addr_o) && $stable(base_en_o)))
    else $error("mem base write took effect"); // R5
  AST_BASE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_addr_o & ~BAR_ADDR) == '0) else $error("base unmasked"); // R5
  AST_STAT_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && !req_mem_i && word_stat) |=> rsp_err_o)
    else $error("status write not flagged"); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_err_o || rsp_unimp_o) |-> (rsp_valid_o && !(rsp_err_o && rsp_unimp_o)))
    else $error("flag conflict"); // R7
  AST_UNIMP_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i) |=> (rsp_unimp_o -> (rsp_rdata_o == '1)))
    else $error("unimp read not ones"); // R7
  AST_OFFSET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req |=> $stable(irq_offset_o)) else $error("offset moved"); // R9
endmodule

bind bridge_regfile brf_checker #(.ADDR_W(ADDR_W)) i_brf_checker (.*);

// File: tb/test_bridge_regfile.sv
module test_bridge_regfile;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_mem_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [63:0] rsp_rdata_o;
  logic        rsp_err_o;
  logic        rsp_unimp_o;
  logic [63:0] base_addr_o;
  logic        base_en_o;
  logic [18:0] irq_offset_o;

  int nchk = 0;
  int nfail = 0;

  logic [63:0] m_fir = '0, m_bar = '0, m_bar2 = '0, m_ctl = '0, m_cmp = '0;
  logic [63:0] m_plain [32];

  always #5 clk_i = ~clk_i;

  bridge_regfile #(.ADDR_W(16)) i_bridge_regfile (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_exports();
    chk(base_addr_o == (m_bar & ~64'h1), "R5", "base_addr", base_addr_o, m_bar & ~64'h1);
    chk(base_en_o == m_bar[0], "R5", "base_en", 64'(base_en_o), 64'(m_bar[0]));
    chk(irq_offset_o == m_cmp[63:45], "R9", "irq_offset", 64'(irq_offset_o), 64'(m_cmp[63:45]));
  endtask

  task automatic txn(input bit mem, input bit we, input logic [15:0] addr,
                     input logic [63:0] d, input string tag);
    int ix;
    logic [63:0] exp_rd;
    bit exp_err, exp_un;
    ix = int'(addr >> 3) + (mem ? 10 : 0);
    exp_rd = '0;
    exp_err = 1'b0;
    exp_un = 1'b0;
    if (!we) begin
      case (ix)
        0:  exp_rd = m_fir;
        6, 7, 15, 20: exp_rd = m_plain[ix];
        10: exp_rd = m_bar;
        11: exp_rd = m_bar2;
        14: exp_rd = m_ctl;
        21: exp_rd = '0;
        27: exp_rd = m_cmp;
        default: begin exp_rd = '1; exp_un = 1'b1; end
      endcase
    end else begin
      case (ix)
        0:  m_fir = d;
        1:  m_fir = m_fir & d;
        2:  m_fir = m_fir | d;
        6, 7, 15, 20: m_plain[ix] = d;
        10: if (mem) exp_err = 1'b1; else m_bar = d & 64'h0003_ffff_fff0_0001;
        11: m_bar2 = d & 64'h0003_ffff_0000_0000;
        14: m_ctl = d;
        18: m_ctl = m_ctl | d;
        19: m_ctl = m_ctl & ~d;
        21: exp_err = 1'b1;
        27: m_cmp = d & 64'hffff_e00f_0000_0000;
        default: exp_un = 1'b1;
      endcase
    end
    req_valid_i = 1'b1;
    req_mem_i   = mem;
    req_we_i    = we;
    req_addr_i  = addr;
    req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(rsp_valid_o == 1'b1 && req_ready_o == 1'b1, "R1", "rsp_valid/ready",
        64'({req_ready_o, rsp_valid_o}), 64'h3);
    chk(rsp_rdata_o == exp_rd, tag, "rdata", rsp_rdata_o, exp_rd);
    chk(rsp_err_o == exp_err, tag, "err", 64'(rsp_err_o), 64'(exp_err));
    chk(rsp_unimp_o == exp_un, tag, "unimp", 64'(rsp_unimp_o), 64'(exp_un));
    check_exports();
  endtask

  task automatic idle();
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R1", "idle rsp_valid", 64'(rsp_valid_o), 64'h0);
    chk(rsp_err_o == 1'b0 && rsp_unimp_o == 1'b0, "R1", "idle flags",
        64'({rsp_err_o, rsp_unimp_o}), 64'h0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int i = 0; i < 32; i++) m_plain[i] = '0;
    repeat (3) @(negedge clk_i);
    // R11: reset state
    chk(rsp_valid_o == 1'b0 && rsp_err_o == 1'b0 && rsp_unimp_o == 1'b0, "R11",
        "reset rsp", 64'({rsp_valid_o, rsp_err_o, rsp_unimp_o}), 64'h0);
    chk(base_addr_o == '0 && base_en_o == 1'b0 && irq_offset_o == '0, "R11",
        "reset exports", base_addr_o, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    txn(0, 0, 16'h0000, '0, "R11");
    txn(0, 0, 16'h0050, '0, "R11");
    txn(0, 0, 16'h0070, '0, "R11");
    txn(0, 0, 16'h00d8, '0, "R11");
    txn(0, 0, 16'h00a0, '0, "R11");

    // R3: fault word aliases
    txn(0, 1, 16'h0000, 64'hf0f0_1234_5678_0ff0, "R3");
    txn(0, 1, 16'h0008, 64'hff00_ff00_ff00_ff00, "R3");
    txn(0, 0, 16'h0000, '0, "R3");
    txn(0, 1, 16'h0010, 64'h0000_0000_0000_000f, "R3");
    txn(0, 0, 16'h0000, '0, "R3");

    // R4 and R2: control word via both paths, low address bits ignored
    txn(1, 1, 16'h0020, 64'h8000_0000_0000_0001, "R2");
    txn(0, 0, 16'h0075, '0, "R2");
    txn(1, 1, 16'h0040, 64'h0400_2000_0000_0000, "R4");
    txn(0, 0, 16'h0070, '0, "R4");
    txn(0, 1, 16'h0098, 64'h8000_2000_0000_0000, "R4");
    txn(1, 0, 16'h0020, '0, "R4");
    txn(0, 1, 16'h0070, 64'h1234_5678_9abc_def0, "R4");
    txn(0, 0, 16'h0070, '0, "R4");

    // R5: window base
    txn(0, 1, 16'h0050, '1, "R5");
    txn(1, 0, 16'h0000, '0, "R5");
    txn(1, 1, 16'h0003, 64'h0000_0000_1230_0000, "R5");
    txn(0, 0, 16'h0050, '0, "R5");
    txn(0, 1, 16'h0050, 64'h0001_0000_0050_0000, "R5");
    txn(0, 0, 16'h0050, '0, "R5");

    // R6: secondary base
    txn(1, 1, 16'h0008, '1, "R6");
    txn(0, 0, 16'h0058, '0, "R6");

    // R7: unimplemented indices and aliases
    txn(0, 0, 16'h0008, '0, "R7");
    txn(0, 0, 16'h0010, '0, "R7");
    txn(0, 0, 16'h0090, '0, "R7");
    txn(0, 0, 16'h0098, '0, "R7");
    txn(0, 0, 16'h0018, '0, "R7");
    txn(0, 1, 16'h0018, '0, "R7");
    txn(0, 1, 16'h00e0, '1, "R7");
    txn(0, 0, 16'hfff8, '0, "R7");
    txn(1, 0, 16'hfff8, '0, "R7");
    txn(1, 1, 16'hfff8, '1, "R7");
    txn(0, 0, 16'h0000, '0, "R7");
    idle();

    // R8: read-only status
    txn(0, 1, 16'h00a8, '1, "R8");
    txn(0, 0, 16'h00a8, '0, "R8");
    txn(1, 1, 16'h0058, '1, "R8");
    txn(1, 0, 16'h0058, '0, "R8");

    // R9: source compare
    txn(0, 1, 16'h00d8, '1, "R9");
    txn(0, 0, 16'h00d8, '0, "R9");
    txn(1, 1, 16'h0088, 64'h0000_2000_0000_0000, "R9");
    txn(1, 0, 16'h0088, '0, "R9");

    // R10: plain storage words
    txn(0, 1, 16'h0030, 64'h0606_0606_0606_0606, "R10");
    txn(0, 1, 16'h0038, 64'h0707_0707_0707_0707, "R10");
    txn(1, 1, 16'h0028, 64'h0f0f_0f0f_0f0f_0f0f, "R10");
    txn(1, 1, 16'h0050, 64'h1414_1414_1414_1414, "R10");
    txn(0, 0, 16'h0030, '0, "R10");
    txn(0, 0, 16'h0038, '0, "R10");
    txn(0, 0, 16'h0078, '0, "R10");
    txn(0, 0, 16'h00a0, '0, "R10");
    idle();
    idle();
    report();
  end
endmodule